// File: doc/BRIEF.md
# Quad-Rail Return-to-Zero Link Repeater

This block cuts a long self-timed point-to-point link into shorter hops. The link carries one symbol at a time on five forward wires: four one-hot data rails, each selecting one two-bit value, and a separate end-of-packet rail. A single acknowledge wire runs back the other way. Every symbol is followed by a return-to-zero phase, so each transfer takes four phases. On both its upstream and downstream sides the repeater has the same five-forward, one-back interface, so it can sit anywhere along the link.

Each stage in the chain keeps one state bit per forward wire. Each bit is a clocked model of a Muller C-element. It sets when its input wire is high and the acknowledge from the next stage is low. It clears when its input wire is low and that acknowledge is high. Otherwise it holds its value. A completion detector ORs the held bits together and drives the acknowledge back toward the sender. The `STAGES` parameter sets how many stages are chained. `ACK_MODE` chooses whether the returned acknowledge is registered or combinational.

Exactly one forward wire is high while a symbol is on the link. An end-of-packet marker is its own symbol on the fifth wire, with all data rails low.

Top module: `qrl_repeater`

## Requirements
- R1: While reset is asserted, every held bit is cleared. `up_ack`, `dn_data` and `dn_eop` are all low on the first clock edge after reset is seen.
- R2: A symbol presented upstream to an empty chain, while `dn_ack` is low, appears unchanged on `dn_data`/`dn_eop` after `STAGES` rising edges. Each stage adds exactly one edge.
- R3: A held symbol stays on its outputs while the acknowledge from the next stage is low, even after its input has returned to zero.
- R4: While the acknowledge from the next stage is high, an empty stage does not capture a new symbol. Once that acknowledge falls, the stage captures the waiting symbol on the next edge.
- R5: With the default registered mode, `up_ack` is high one edge after the first stage holds a symbol. It falls one edge after that stage empties. So it rises two edges after a symbol reaches an empty chain.
- R6: A stage whose input is all-zero clears on the next edge when the acknowledge from the next stage is high. After the stage nearest the output has a zero input, `dn_data`/`dn_eop` drop one edge after `dn_ack` rises.
- R7: The end-of-packet wire (bit index RAILS of the internal five-bit bundle) travels like any other rail. An end-of-packet symbol shows `dn_eop` high with `dn_data` zero.
- R8: A stream of symbols driven under the four-phase protocol comes out in the same order, none lost and none duplicated, for any delay the receiver inserts before raising or lowering `dn_ack`.
- R9: Each stage holds at most one high bit across its five state bits at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Emulation clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_data | input | RAILS | One-hot data rails from the sender |
| up_eop | input | 1 | End-of-packet rail from the sender |
| up_ack | output | 1 | Completion acknowledge returned to the sender |
| dn_data | output | RAILS | One-hot data rails toward the receiver |
| dn_eop | output | 1 | End-of-packet rail toward the receiver |
| dn_ack | input | 1 | Acknowledge from the receiver |

## Verification
The timing is fixed by the number of stages, and the bench checks against those counts. A symbol reaches the downstream pins on edge `STAGES`. `up_ack` rises on edge two after the symbol arrives, and falls a couple of edges after the sender returns to zero. The outputs drop on the first edge after `dn_ack` rises once the stage nearest the output sees a zero input. The bench drives on falling edges and samples on the falling edge right after the counted rising edge. It never samples before that edge. The directed steps check both sides of each boundary: empty before edge `STAGES` and full on it, blocked while `dn_ack` is high and captured one edge after it drops. A free-running stream with randomly delayed receiver acknowledges then sweeps every symbol value and compares the received order with the sent order.

// File: rtl/qrl_pkg.sv
package qrl_pkg;

   // Source of the acknowledge a stage returns upstream.
   typedef enum logic {
      ACK_COMB = 1'b0,   // completion OR drives the wire directly
      ACK_REG  = 1'b1    // completion OR goes through one flop
   } qrl_ack_mode_e;

   localparam int unsigned QRL_RAILS_DEFAULT  = 4;
   localparam int unsigned QRL_STAGES_DEFAULT = 3;

endpackage

// File: rtl/qrl_celem.sv
module qrl_celem (
   input  logic clk,
   input  logic rst_n,
   input  logic in_bit,
   input  logic ack_dn,
   output logic held
);

   // Muller C-element emulated with a flop: set on (in & ~ack),
   // clear on (~in & ack), hold otherwise.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held <= 1'b0;
      end else if (in_bit && !ack_dn) begin
         held <= 1'b1;
      end else if (!in_bit && ack_dn) begin
         held <= 1'b0;
      end
   end

endmodule

// File: rtl/qrl_completion.sv
module qrl_completion
   import qrl_pkg::*;
#(
   parameter int unsigned   WIDTH    = 5,
   parameter qrl_ack_mode_e ACK_MODE = ACK_REG
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] held,
   output logic             done
);

   logic any_set;

   if (WIDTH < 2) begin : g_bad_width
      $error("qrl_completion: WIDTH must be at least 2");
   end

   assign any_set = |held;

   if (ACK_MODE == ACK_REG) begin : g_reg
      logic done_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            done_q <= 1'b0;
         end else begin
            done_q <= any_set;
         end
      end
      assign done = done_q;
   end else begin : g_comb
      // clk/rst_n unused in this variant
      logic unused_ok;
      assign unused_ok = clk ^ rst_n;
      assign done = any_set;
   end

endmodule

// File: rtl/qrl_stage.sv
module qrl_stage
   import qrl_pkg::*;
#(
   parameter int unsigned   RAILS    = QRL_RAILS_DEFAULT,
   parameter qrl_ack_mode_e ACK_MODE = ACK_REG
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [RAILS:0] fwd_in,
   input  logic           ack_dn,
   output logic [RAILS:0] fwd_out,
   output logic           ack_up
);

   localparam int unsigned WIRES = RAILS + 1;

   if (RAILS < 2) begin : g_bad_rails
      $error("qrl_stage: RAILS must be at least 2");
   end

   // One C-element per forward wire (data rails plus end-of-packet).
   for (genvar w = 0; w < WIRES; w++) begin : g_bit
      qrl_celem u_cel (
         .clk    (clk),
         .rst_n  (rst_n),
         .in_bit (fwd_in[w]),
         .ack_dn (ack_dn),
         .held   (fwd_out[w])
      );
   end

   qrl_completion #(
      .WIDTH    (WIRES),
      .ACK_MODE (ACK_MODE)
   ) u_cd (
      .clk   (clk),
      .rst_n (rst_n),
      .held  (fwd_out),
      .done  (ack_up)
   );

endmodule

// File: rtl/qrl_repeater.sv
module qrl_repeater
   import qrl_pkg::*;
#(
   parameter int unsigned   RAILS    = QRL_RAILS_DEFAULT,
   parameter int unsigned   STAGES   = QRL_STAGES_DEFAULT,
   parameter qrl_ack_mode_e ACK_MODE = ACK_REG
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [RAILS-1:0] up_data,
   input  logic             up_eop,
   output logic             up_ack,
   output logic [RAILS-1:0] dn_data,
   output logic             dn_eop,
   input  logic             dn_ack
);

   if (RAILS < 2) begin : g_bad_rails
      $error("qrl_repeater: RAILS must be at least 2");
   end
   if (STAGES < 1) begin : g_bad_stages
      $error("qrl_repeater: STAGES must be at least 1");
   end

   // link_fwd[k] is the bundle entering stage k (k = 0 is the sender side);
   // link_ack[k] is the acknowledge seen by whoever drives link_fwd[k].
   logic [RAILS:0] link_fwd [STAGES+1];
   logic           link_ack [STAGES+1];

   assign link_fwd[0]      = {up_eop, up_data};
   assign link_ack[STAGES] = dn_ack;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      qrl_stage #(
         .RAILS    (RAILS),
         .ACK_MODE (ACK_MODE)
      ) u_stg (
         .clk     (clk),
         .rst_n   (rst_n),
         .fwd_in  (link_fwd[g]),
         .ack_dn  (link_ack[g+1]),
         .fwd_out (link_fwd[g+1]),
         .ack_up  (link_ack[g])
      );
   end

   assign up_ack  = link_ack[0];
   assign dn_data = link_fwd[STAGES][RAILS-1:0];
   assign dn_eop  = link_fwd[STAGES][RAILS];

endmodule

// File: rtl/qrl_repeater_chk.sv
module qrl_repeater_chk
   import qrl_pkg::*;
#(
   parameter int unsigned   RAILS    = QRL_RAILS_DEFAULT,
   parameter int unsigned   STAGES   = QRL_STAGES_DEFAULT,
   parameter qrl_ack_mode_e ACK_MODE = ACK_REG
) (
   input logic             clk,
   input logic             rst_n,
   input logic [RAILS:0]   link_fwd [STAGES+1],
   input logic             link_ack [STAGES+1],
   input logic             up_ack,
   input logic [RAILS-1:0] dn_data,
   input logic             dn_eop
);

   // R1: outputs quiet after a reset cycle
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!up_ack && dn_data == '0 && !dn_eop));

   for (genvar k = 1; k <= STAGES; k++) begin : g_st
      // R2: empty stage with low ack takes its input on the next edge
      a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
         (link_fwd[k] == '0 && !link_ack[k] && link_fwd[k-1] != '0)
         |=> (link_fwd[k] == $past(link_fwd[k-1])));

      // R3: a held symbol is kept while the next stage's ack is low
      a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (link_fwd[k] != '0 && !link_ack[k])
         |=> (link_fwd[k] == $past(link_fwd[k])));

      // R4: an empty stage stays empty while the next ack is high
      a_r4_block: assert property (@(posedge clk) disable iff (!rst_n)
         (link_fwd[k] == '0 && link_ack[k]) |=> (link_fwd[k] == '0));

      // R6: zero input with high ack empties the stage
      a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (link_fwd[k-1] == '0 && link_ack[k]) |=> (link_fwd[k] == '0));

      // R9: never more than one held bit per stage
      a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(link_fwd[k]));

      // R5: returned ack tracks completion of this stage
      if (ACK_MODE == ACK_REG) begin : g_ackr
         a_r5_ack_reg: assert property (@(posedge clk) disable iff (!rst_n)
            link_ack[k-1] == $past(link_fwd[k] != '0));
      end else begin : g_ackc
         a_r5_ack_comb: assert property (@(posedge clk) disable iff (!rst_n)
            link_ack[k-1] == (link_fwd[k] != '0));
      end
   end

endmodule

bind qrl_repeater qrl_repeater_chk #(
   .RAILS    (RAILS),
   .STAGES   (STAGES),
   .ACK_MODE (ACK_MODE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .link_fwd (link_fwd),
   .link_ack (link_ack),
   .up_ack   (up_ack),
   .dn_data  (dn_data),
   .dn_eop   (dn_eop)
);

// File: tb/qrl_repeater_tb.sv
module qrl_repeater_tb;

   localparam int RAILS  = 4;
   localparam int STAGES = 3;
   localparam int NSYM   = 60;

   logic             clk = 1'b0;
   logic             rst_n = 1'b1;
   logic [RAILS-1:0] up_data = '0;
   logic             up_eop = 1'b0;
   logic             up_ack;
   logic [RAILS-1:0] dn_data;
   logic             dn_eop;
   logic             dn_ack = 1'b0;

   int n_tests = 0;
   int n_fail  = 0;
   bit auto_rx = 1'b0;
   int rx_n = 0;
   int rx_q [NSYM];
   int tx_q [NSYM];
   int onehot_err = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   qrl_repeater #(.RAILS(RAILS), .STAGES(STAGES)) u_dut (
      .clk(clk), .rst_n(rst_n), .up_data(up_data), .up_eop(up_eop),
      .up_ack(up_ack), .dn_data(dn_data), .dn_eop(dn_eop), .dn_ack(dn_ack)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int dn_bundle();
      return int'({dn_eop, dn_data});
   endfunction

   // symbol index 0..RAILS-1 = data rail, RAILS = end-of-packet
   task automatic drive_sym(input int idx);
      up_data = '0;
      up_eop  = 1'b0;
      if (idx == RAILS) up_eop = 1'b1;
      else up_data[idx] = 1'b1;
   endtask

   task automatic drive_zero();
      up_data = '0;
      up_eop  = 1'b0;
   endtask

   task automatic send_sym(input int idx, input int gap);
      while (up_ack) @(negedge clk);
      drive_sym(idx);
      do @(negedge clk); while (!up_ack);
      drive_zero();
      repeat (gap) @(negedge clk);
   endtask

   task automatic flush();
      drive_zero();
      for (int i = 0; i < STAGES + 1; i++) begin
         dn_ack = 1'b0;
         repeat (4) @(negedge clk);
         dn_ack = 1'b1;
         repeat (4) @(negedge clk);
      end
      dn_ack = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   // R9 monitor on the downstream pins
   always @(negedge clk) begin
      if (rst_n && $countones({dn_eop, dn_data}) > 1) onehot_err++;
   end

   // automatic receiver with random acknowledge delays
   initial begin
      forever begin
         @(negedge clk);
         if (auto_rx && !dn_ack && dn_bundle() != 0) begin
            int idx;
            idx = -1;
            for (int b = 0; b <= RAILS; b++)
               if (dn_bundle() == (1 << b)) idx = b;
            if (rx_n < NSYM) rx_q[rx_n] = idx;
            rx_n++;
            repeat ($urandom_range(0, 3)) @(negedge clk);
            dn_ack = 1'b1;
            while (dn_bundle() != 0) @(negedge clk);
            repeat ($urandom_range(0, 3)) @(negedge clk);
            dn_ack = 1'b0;
         end
      end
   end

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", rx_n, NSYM);
         summary();
      end
   end

   initial begin
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(up_ack == 1'b0, "R1 up_ack", int'(up_ack), 0);
      chk(dn_bundle() == 0, "R1 dn outputs", dn_bundle(), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 / R5: latency through the chain and ack rise
      drive_sym(2);
      for (int k = 1; k <= STAGES; k++) begin
         @(negedge clk);
         chk(dn_bundle() == ((k == STAGES) ? 4 : 0), "R2 latency", dn_bundle(),
             (k == STAGES) ? 4 : 0);
         chk(up_ack == (k >= 2), "R5 ack rise", int'(up_ack), int'(k >= 2));
      end

      // R3: hold with dn_ack low after upstream RTZ; R5 ack falls
      drive_zero();
      repeat (4) @(negedge clk);
      chk(dn_bundle() == 4, "R3 hold", dn_bundle(), 4);
      chk(up_ack == 1'b0, "R5 ack fall", int'(up_ack), 0);

      // R6: outputs drop one edge after dn_ack rises
      dn_ack = 1'b1;
      @(negedge clk);
      chk(dn_bundle() == 0, "R6 clear", dn_bundle(), 0);
      dn_ack = 1'b0;
      repeat (3) @(negedge clk);

      // R4: blocked while dn_ack high, released one edge after it drops
      dn_ack = 1'b1;
      repeat (3) @(negedge clk);
      drive_sym(0);
      repeat (6) @(negedge clk);
      chk(dn_bundle() == 0, "R4 blocked", dn_bundle(), 0);
      chk(up_ack == 1'b1, "R4 upstream filled", int'(up_ack), 1);
      dn_ack = 1'b0;
      @(negedge clk);
      chk(dn_bundle() == 1, "R4 release", dn_bundle(), 1);
      flush();
      chk(dn_bundle() == 0, "R6 flush empty", dn_bundle(), 0);

      // R7: end-of-packet symbol
      drive_sym(RAILS);
      repeat (STAGES) @(negedge clk);
      chk(dn_eop == 1'b1 && dn_data == '0, "R7 eop", dn_bundle(), 1 << RAILS);
      flush();

      // R8: stream sweep over every symbol with random receiver delays
      auto_rx = 1'b1;
      for (int i = 0; i < NSYM; i++) begin
         tx_q[i] = (i * 3 + i / 5) % (RAILS + 1);
         send_sym(tx_q[i], i % 3);
      end
      while (rx_n < NSYM) @(negedge clk);
      repeat (20) @(negedge clk);
      chk(rx_n == NSYM, "R8 symbol count", rx_n, NSYM);
      for (int i = 0; i < NSYM; i++)
         chk(rx_q[i] == tx_q[i], "R8 order", rx_q[i], tx_q[i]);
      chk(onehot_err == 0, "R9 onehot", onehot_err, 0);

      done = 1'b1;
      summary();
   end

endmodule